// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual page number into a physical page number when the translation cache misses. The walk goes through a two-level map held in main memory. The upper bits of the virtual page number select a word in a page directory. That directory sits in the physical page named by a base input, and the software that switches contexts rewrites this base input. A resident directory word names the physical page that holds one segment of the page map. The lower bits of the virtual page number then select the final entry inside that segment. The block makes one or two word reads per walk, one at a time. If either level is marked absent, it returns a fault instead of a page number.

Requests enter through a valid/ready port. `req_ready` is high only while the walker is idle, so at most one walk is in flight at any time. The result leaves on a valid/ready port. The payload is held unchanged from the cycle `rsp_valid` rises until the consumer raises `rsp_ready`. Memory reads leave on a valid/ready request port: the address is held until `mem_req_ready` is sampled high. The data comes back on a valid-only return port, at least one cycle after the request is accepted. `base_ppn` is a plain level input and is sampled only when a request is accepted.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready`=1, `rsp_valid`=0 and `mem_req_valid`=0. `req_ready` falls in the cycle after a request is accepted and rises again only after the response has been taken.
- R2: The first read of a walk uses the byte address base_ppn*4096 + vpn[19:10]*4.
- R3: A directory word with bit 31 equal to 0 ends the walk with `rsp_fault`=1 and `rsp_level`=0, and no second read is issued.
- R4: A directory word with bit 31 equal to 1 leads to a second read at {dir_word[19:0], vpn[9:0], 2'b00}.
- R5: A segment entry with bit 31 equal to 0 gives `rsp_fault`=1, `rsp_level`=1 and `rsp_ppn`=0.
- R6: A segment entry with bit 31 equal to 1 gives `rsp_fault`=0, `rsp_level`=0 and `rsp_ppn`=entry[19:0]. Bits 30:20 of the entry are ignored.
- R7: While `mem_req_valid`=1 and `mem_req_ready`=0, the next cycle still has `mem_req_valid`=1 with the same `mem_addr`.
- R8: While `rsp_valid`=1 and `rsp_ready`=0, the next cycle still has `rsp_valid`=1 with unchanged `rsp_ppn`, `rsp_fault` and `rsp_level`.
- R9: A change of `base_ppn` after a request has been accepted does not affect that walk. The next walk uses the new value.
- R10: A `mem_rsp_valid` pulse while no read is outstanding is ignored. The walker stays idle and raises no response.
- R11: No new read is requested between the acceptance of a read and the return of its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_ppn | input | 20 | Physical page number of the current page directory |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vpn | input | 20 | Virtual page number to translate |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_ppn | output | 20 | Translated physical page number (0 on a fault) |
| rsp_fault | output | 1 | Page fault |
| rsp_level | output | 1 | Fault level: 0 = directory, 1 = segment entry |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |

## Verification
The bench builds the walker with its default parameters: a 32-bit address, a 12-bit page offset and a 32-bit word. These give a 10-bit directory index and a 10-bit segment index. With these values, indices 0 and 1023 can be reached in both levels. So can a page number with every bit set, and an entry whose bits 30:20 are set but must be dropped. A base page that changes mid-walk is covered, and so are memory ready gaps, response latencies and consumer stalls of several cycles.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  typedef enum logic [4:0] {
    S_IDLE = 5'b00001,
    S_DIR  = 5'b00010,
    S_PTE  = 5'b00100,
    S_DONE = 5'b01000,
    S_FLT  = 5'b10000
  } walk_st_e;

  localparam logic LVL_DIR = 1'b0;
  localparam logic LVL_SEG = 1'b1;
endpackage

// File: rtl/pt_entry_dec.sv
module pt_entry_dec #(
  parameter int WORD_W  = 32,
  parameter int PPN_W   = 20,
  parameter int RES_BIT = 31
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              resident_o,
  output logic [PPN_W-1:0]  ppn_o
);
  // resident flag and page number fields of a map word
  assign resident_o = word_i[RES_BIT];
  assign ppn_o      = word_i[PPN_W-1:0];

  initial begin
    if (RES_BIT < PPN_W || RES_BIT >= WORD_W)
      $error("resident flag overlaps the page number field");
  end
endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int WORD_W = 32
) (
  input  logic [ADDR_W-OFF_W-1:0] base_ppn_i,
  input  logic [ADDR_W-OFF_W-1:0] vpn_i,
  input  logic [ADDR_W-OFF_W-1:0] seg_ppn_i,
  input  logic                    second_i,
  output logic [ADDR_W-1:0]       addr_o
);
  localparam int BYTE_SH = $clog2(WORD_W / 8);
  localparam int VPN_W   = ADDR_W - OFF_W;
  localparam int SEG_W   = OFF_W - BYTE_SH;
  localparam int DIR_W   = VPN_W - SEG_W;

  logic [DIR_W-1:0]  dir_idx;
  logic [SEG_W-1:0]  seg_idx;
  logic [ADDR_W-1:0] dir_addr;
  logic [ADDR_W-1:0] seg_addr;

  assign dir_idx = vpn_i[VPN_W-1:SEG_W];
  assign seg_idx = vpn_i[SEG_W-1:0];

  // directory word: base page plus scaled upper index (may span pages)
  assign dir_addr = {base_ppn_i, {OFF_W{1'b0}}}
                  + ADDR_W'({dir_idx, {BYTE_SH{1'b0}}});
  // segment word: one page holds exactly 2^SEG_W words
  assign seg_addr = {seg_ppn_i, seg_idx, {BYTE_SH{1'b0}}};

  assign addr_o = second_i ? seg_addr : dir_addr;
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walk_pkg::*;
#(
  parameter int PPN_W = 20,
  parameter int VPN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PPN_W-1:0] base_ppn_i,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PPN_W-1:0] rsp_ppn,
  output logic             rsp_fault,
  output logic             rsp_level,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  input  logic             ent_resident,
  input  logic [PPN_W-1:0] ent_ppn,
  output logic [VPN_W-1:0] vpn_q,
  output logic [PPN_W-1:0] base_q,
  output logic [PPN_W-1:0] seg_q,
  output logic             second_o
);
  walk_st_e         st;
  logic             sent;
  logic [PPN_W-1:0] ppn_q;
  logic             lvl_q;
  logic             data_in;

  assign data_in = sent && mem_rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sent   <= 1'b0;
      vpn_q  <= '0;
      base_q <= '0;
      seg_q  <= '0;
      ppn_q  <= '0;
      lvl_q  <= LVL_DIR;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (req_valid) begin
            vpn_q  <= req_vpn;
            base_q <= base_ppn_i;
            sent   <= 1'b0;
            st     <= S_DIR;
          end
        end
        S_DIR: begin
          if (!sent) begin
            if (mem_req_ready) sent <= 1'b1;
          end else if (data_in) begin
            sent <= 1'b0;
            if (ent_resident) begin
              seg_q <= ent_ppn;
              st    <= S_PTE;
            end else begin
              ppn_q <= '0;
              lvl_q <= LVL_DIR;
              st    <= S_FLT;
            end
          end
        end
        S_PTE: begin
          if (!sent) begin
            if (mem_req_ready) sent <= 1'b1;
          end else if (data_in) begin
            sent <= 1'b0;
            if (ent_resident) begin
              ppn_q <= ent_ppn;
              lvl_q <= LVL_DIR;
              st    <= S_DONE;
            end else begin
              ppn_q <= '0;
              lvl_q <= LVL_SEG;
              st    <= S_FLT;
            end
          end
        end
        S_DONE, S_FLT: begin
          if (rsp_ready) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_DIR || st == S_PTE) && !sent;
  assign rsp_valid     = (st == S_DONE) || (st == S_FLT);
  assign rsp_fault     = (st == S_FLT);
  assign rsp_level     = lvl_q;
  assign rsp_ppn       = ppn_q;
  assign second_o      = (st == S_PTE);

  // R1: exactly one state bit set
  p_onehot_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(st) == 1);
  // R1: accepting requests excludes any other activity
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !mem_req_valid));
  // R1: acceptance drops ready in the next cycle
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R3: absent directory word goes straight to a fault
  p_dir_fault_no_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DIR && data_in && !ent_resident) |=>
      (rsp_fault && rsp_level == LVL_DIR && !mem_req_valid));
  // R7: request held under back-pressure
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid);
  // R8: response held under back-pressure
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_ppn) && $stable(rsp_fault) && $stable(rsp_level)));
  // R10: stray return data while idle changes nothing
  p_ignore_stray_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !req_valid) |=> (st == S_IDLE));
  // R11: accepted read blocks further requests until data returns
  p_single_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int WORD_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-OFF_W-1:0] base_ppn,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-OFF_W-1:0] req_vpn,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [ADDR_W-OFF_W-1:0] rsp_ppn,
  output logic                    rsp_fault,
  output logic                    rsp_level,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [ADDR_W-1:0]       mem_addr,
  input  logic                    mem_rsp_valid,
  input  logic [WORD_W-1:0]       mem_rsp_data
);
  localparam int PPN_W   = ADDR_W - OFF_W;
  localparam int VPN_W   = ADDR_W - OFF_W;
  localparam int RES_BIT = WORD_W - 1;

  logic             ent_resident;
  logic [PPN_W-1:0] ent_ppn;
  logic [VPN_W-1:0] vpn_q;
  logic [PPN_W-1:0] base_q;
  logic [PPN_W-1:0] seg_q;
  logic             second;

  pt_entry_dec #(.WORD_W(WORD_W), .PPN_W(PPN_W), .RES_BIT(RES_BIT)) u_dec (
    .word_i    (mem_rsp_data),
    .resident_o(ent_resident),
    .ppn_o     (ent_ppn)
  );

  pt_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .WORD_W(WORD_W)) u_addr (
    .base_ppn_i(base_q),
    .vpn_i     (vpn_q),
    .seg_ppn_i (seg_q),
    .second_i  (second),
    .addr_o    (mem_addr)
  );

  pt_walk_ctrl #(.PPN_W(PPN_W), .VPN_W(VPN_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .base_ppn_i   (base_ppn),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_vpn      (req_vpn),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_ppn      (rsp_ppn),
    .rsp_fault    (rsp_fault),
    .rsp_level    (rsp_level),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .ent_resident (ent_resident),
    .ent_ppn      (ent_ppn),
    .vpn_q        (vpn_q),
    .base_q       (base_q),
    .seg_q        (seg_q),
    .second_o     (second)
  );

  // R7: address stays put while the memory stalls
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> $stable(mem_addr));
  // R9: the walk's address source ignores the live base input once busy
  p_base_isolated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$changed(req_ready)) |-> $stable(base_q));
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] base_ppn;
  logic        req_valid;
  logic        req_ready;
  logic [19:0] req_vpn;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [19:0] rsp_ppn;
  logic        rsp_fault;
  logic        rsp_level;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  always #10 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n), .base_ppn(base_ppn),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ppn(rsp_ppn),
    .rsp_fault(rsp_fault), .rsp_level(rsp_level),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  typedef struct packed {
    logic [19:0] ppn;
    logic        fault;
    logic        lvl;
  } exp_t;

  logic [31:0] mem_img [logic [31:0]];
  logic [31:0] exp_addr_q [$];
  string       addr_tag_q [$];
  exp_t        exp_q [$];
  string       rsp_tag_q [$];

  int checks = 0;
  int errors = 0;
  int mem_gap = 0;
  int mem_lat = 1;
  int rsp_gap = 0;
  int cyc = 0;
  bit spur = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem_img.exists(a)) return mem_img[a];
    return 32'h0;
  endfunction

  // memory model: ready pattern, fixed latency, address scoreboard
  int          lat_cnt = 0;
  logic [31:0] lat_data;
  bit          prev_mem_stall = 1'b0;
  logic [31:0] prev_addr;
  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = 1'b0;
    if (lat_cnt > 0) begin
      lat_cnt--;
      if (lat_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = lat_data;
      end
    end
    if (spur) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = 32'h8000_0005;
    end
    mem_req_ready = (mem_gap == 0) || (cyc % (mem_gap + 1) == 0);
    if (rst_n) begin
      if (prev_mem_stall)
        chk(mem_req_valid && mem_addr == prev_addr, "R7", "held request",
            {31'h0, mem_req_valid, mem_addr}, {32'h1, prev_addr});
      prev_mem_stall = mem_req_valid && !mem_req_ready;
      prev_addr      = mem_addr;
      if (mem_req_valid && mem_req_ready) begin
        if (exp_addr_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected read", 64'(mem_addr), 64'h0);
        end else begin
          logic [31:0] e;
          string       t;
          e = exp_addr_q.pop_front();
          t = addr_tag_q.pop_front();
          chk(mem_addr == e, t, "read address", 64'(mem_addr), 64'(e));
        end
        lat_cnt  = mem_lat;
        lat_data = rd(mem_addr);
      end
    end
  end

  // response monitor: ready pattern, hold check, result scoreboard
  bit   prev_rsp_stall = 1'b0;
  exp_t prev_rsp;
  always @(negedge clk) begin
    rsp_ready = (rsp_gap == 0) || (cyc % (rsp_gap + 1) == 0);
    if (rst_n) begin
      if (prev_rsp_stall)
        chk(rsp_valid && {rsp_ppn, rsp_fault, rsp_level} == prev_rsp, "R8",
            "held response", {rsp_valid, rsp_ppn, rsp_fault, rsp_level},
            {1'b1, prev_rsp});
      prev_rsp_stall = rsp_valid && !rsp_ready;
      prev_rsp       = {rsp_ppn, rsp_fault, rsp_level};
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1", "unexpected response", 64'(rsp_ppn), 64'h0);
        end else begin
          exp_t  e;
          string t;
          e = exp_q.pop_front();
          t = rsp_tag_q.pop_front();
          chk({rsp_ppn, rsp_fault, rsp_level} == e, t, "result",
              64'({rsp_ppn, rsp_fault, rsp_level}), 64'(e));
          chk(exp_addr_q.size() == 0, t, "reads left over",
              64'(exp_addr_q.size()), 64'h0);
        end
      end
    end
  end

  // driver: expected reads and result from R2..R6, then the request
  task automatic walk(input logic [19:0] vpn, input string tag,
                      input bit swap, input logic [19:0] nb);
    logic [31:0] a1, a2, d, p;
    while (!req_ready) @(negedge clk);
    a1 = {base_ppn, 12'h0} + {20'h0, vpn[19:10], 2'b00};
    exp_addr_q.push_back(a1);
    addr_tag_q.push_back("R2");
    d = rd(a1);
    if (!d[31]) begin
      exp_q.push_back('{ppn: 20'h0, fault: 1'b1, lvl: 1'b0});
    end else begin
      a2 = {d[19:0], vpn[9:0], 2'b00};
      exp_addr_q.push_back(a2);
      addr_tag_q.push_back("R4");
      p = rd(a2);
      if (!p[31]) exp_q.push_back('{ppn: 20'h0, fault: 1'b1, lvl: 1'b1});
      else        exp_q.push_back('{ppn: p[19:0], fault: 1'b0, lvl: 1'b0});
    end
    rsp_tag_q.push_back(tag);
    req_valid = 1'b1;
    req_vpn   = vpn;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1", "busy after accept", 64'(req_ready), 64'h0);
    if (swap) base_ppn = nb;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || !req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    // base page 0x10: directory at 0x10000
    mem_img[32'h0001_0000] = 32'h8000_0020;
    mem_img[32'h0001_0FFC] = 32'h8000_0021;
    mem_img[32'h0001_0014] = 32'h0000_0020;
    mem_img[32'h0002_0000] = 32'h800A_BCDE;
    mem_img[32'h0002_000C] = 32'h0001_2345;
    mem_img[32'h0002_0010] = 32'hFFF5_4321;
    mem_img[32'h0002_1FFC] = 32'hFFFF_FFFF;
    // base page 0x11: directory at 0x11000
    mem_img[32'h0001_1000] = 32'h8000_0030;
    mem_img[32'h0003_0000] = 32'h8001_1111;

    rst_n     = 1'b0;
    base_ppn  = 20'h00010;
    req_valid = 1'b0;
    req_vpn   = '0;
    mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset req_ready", 64'(req_ready), 64'h1);
    chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", 64'(rsp_valid), 64'h0);
    chk(mem_req_valid == 1'b0, "R1", "reset mem_req_valid", 64'(mem_req_valid), 64'h0);

    // no stalls
    walk(20'h00000, "R6", 1'b0, 20'h0);
    walk(20'hFFFFF, "R6", 1'b0, 20'h0);
    walk({10'd5, 10'd0}, "R3", 1'b0, 20'h0);
    walk({10'd0, 10'd3}, "R5", 1'b0, 20'h0);
    walk({10'd0, 10'd4}, "R6", 1'b0, 20'h0);
    walk({10'd7, 10'd9}, "R3", 1'b0, 20'h0);
    drain();

    // back-pressure on both sides, longer latency
    mem_gap = 2; mem_lat = 3; rsp_gap = 3;
    walk(20'h00000, "R6", 1'b0, 20'h0);
    walk({10'd0, 10'd3}, "R5", 1'b0, 20'h0);
    walk({10'd5, 10'd1}, "R3", 1'b0, 20'h0);
    walk(20'hFFFFF, "R6", 1'b0, 20'h0);
    drain();

    // base change during a walk, then a walk with the new base
    walk(20'h00000, "R9", 1'b1, 20'h00011);
    walk(20'h00000, "R9", 1'b0, 20'h0);
    drain();

    // stray return data while idle
    mem_gap = 0; mem_lat = 1; rsp_gap = 0;
    spur = 1'b1;
    @(negedge clk);
    spur = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R10", "idle after stray data",
        {rsp_valid, req_ready}, 64'h1);
    chk(mem_req_valid == 1'b0, "R11", "no read after stray data",
        64'(mem_req_valid), 64'h0);
    walk(20'h00000, "R10", 1'b0, 20'h0);
    drain();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=busy expected=idle");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule